// File: doc/BRIEF.md
# Program Memory Fetch Selector

This block sits between a processor's instruction fetch port and two program stores: an on-chip program array that holds the low part of a 16-bit code space, and an external program bus. A strap input picks the store. The block captures the strap while reset is held and keeps that choice until the next reset. Every fetch then goes either to the external bus or to the on-chip array, depending only on the captured choice.

In on-chip mode the array stops short of the top of the code space. Fetches that land in the region above it never reach the external bus. They complete with a no-operation opcode of 00H. The processor issues one fetch at a time through a request/ready handshake and receives a one-cycle valid strobe with the opcode. A fetch carries either an explicit address or a "next sequential" flag. The sequential address is one more than the previous fetch address and wraps from FFFFH to 0000H inside the selected store.

Top module: `progmem_fetch_sel`

## Requirements
- R1: If the strap is low at the last clock edge with reset asserted, every fetch, at any address including F800H to FFFFH, goes out on the external bus and the on-chip array read strobe never rises.
- R2: If the strap is high at the last clock edge with reset asserted, a fetch at an address below F800H reads the on-chip array at that address and returns the array's byte.
- R3: After reset is released, changes on the strap pin have no effect on routing until reset is asserted again.
- R4: In on-chip mode the external bus request never rises, for any fetch address.
- R5: In on-chip mode a fetch at any address from F800H to FFFFH returns opcode 00H one cycle after acceptance, without reading the on-chip array.
- R6: An on-chip array fetch raises the fetch valid strobe in the cycle after the fetch is accepted, carrying the data the array returns in that cycle (array read latency of one cycle).
- R7: An external fetch holds the bus request high with a stable address until the acknowledge. The valid strobe rises in the acknowledge cycle and carries the bus data. The request falls in the following cycle.
- R8: A fetch with the sequential flag set uses the previous accepted address plus one, modulo 2^16. The first sequential fetch after reset uses 0000H. A sequential step from FFFFH goes to 0000H in the selected store.
- R9: Out of reset, ready is high and valid, the bus request and the array read strobe are low. Ready is low from acceptance until the valid cycle, and requests presented while ready is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously |
| boot_strap_i | input | 1 | Store select strap: 1 on-chip, 0 external |
| fetch_req_i | input | 1 | Fetch request from the processor |
| fetch_seq_i | input | 1 | Use previous address plus one instead of fetch_addr_i |
| fetch_addr_i | input | 16 | Explicit fetch address |
| fetch_ready_o | output | 1 | Block is idle and will accept a request |
| fetch_valid_o | output | 1 | Opcode on fetch_data_o is valid this cycle |
| fetch_data_o | output | 8 | Returned opcode |
| iarr_rd_o | output | 1 | On-chip array read strobe |
| iarr_addr_o | output | 16 | On-chip array read address |
| iarr_data_i | input | 8 | On-chip array data, one cycle after the strobe |
| xbus_req_o | output | 1 | External bus request |
| xbus_addr_o | output | 16 | External bus address |
| xbus_ack_i | input | 1 | External bus acknowledge |
| xbus_data_i | input | 8 | External bus data, valid with the acknowledge |

## Verification
The bench fetches from F800H, from interior addresses of the top region and from FFFFH in on-chip mode. It counts bus requests and high array reads, so a design that rolled over to the external store, or read past the array end, is caught by counters as well as by wrong data. A sequential step across FFFFH checks that the wrap lands on the array at 0000H and not on the bus. Another test toggles the strap after reset to expose a selector that follows the live pin. An external fetch with a slow acknowledge shows whether a stray second request during the wait is wrongly accepted, and whether valid arrives early or late relative to the acknowledge.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

   typedef enum logic {
      MODE_EXT = 1'b0,
      MODE_INT = 1'b1
   } pfs_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_IWAIT = 2'd1,
      ST_NOP   = 2'd2,
      ST_XWAIT = 2'd3
   } pfs_state_e;

   typedef struct packed {
      logic to_int;
      logic to_nop;
      logic to_ext;
   } pfs_route_t;

endpackage

// File: rtl/pfs_mode_latch.sv
module pfs_mode_latch
   import pfs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      strap_i,
   output pfs_mode_e mode_o
);

   pfs_mode_e mode_q;

   // Follows the strap on every edge while reset is held, frozen afterwards.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= pfs_mode_e'(strap_i);
      end
   end

   assign mode_o = mode_q;

   // R3: the captured store choice never moves while out of reset
   p_mode_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(mode_q));

endmodule

// File: rtl/pfs_addr_gen.sv
module pfs_addr_gen #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic              seq_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] cur_o,
   output logic [ADDR_W-1:0] held_o
);

   localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] RESET_PTR = '1;

   logic [ADDR_W-1:0] held_q;

   // Modulo 2^ADDR_W step: the carry out of the top bit is dropped.
   always_comb begin
      if (seq_i) begin
         cur_o = held_q + ONE;
      end else begin
         cur_o = addr_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= RESET_PTR;
      end else if (accept_i) begin
         held_q <= cur_o;
      end
   end

   assign held_o = held_q;

   // R8: the held address only changes when a fetch is accepted
   p_held_only_on_accept_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(accept_i) && $past(rst_n) |-> $stable(held_q));

endmodule

// File: rtl/pfs_route.sv
module pfs_route
   import pfs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned INT_TOP = 32'h0000_F800
) (
   input  pfs_mode_e         mode_i,
   input  logic [ADDR_W-1:0] addr_i,
   output pfs_route_t        route_o
);

   localparam logic [ADDR_W:0] TOP_X   = (ADDR_W+1)'(INT_TOP);
   localparam int unsigned     SPACE   = 32'd1 << ADDR_W;
   localparam bit              HAS_NOP = (INT_TOP < SPACE);

   logic above_top;

   generate
      if (HAS_NOP) begin : g_nop_region
         assign above_top = ({1'b0, addr_i} >= TOP_X);
      end else begin : g_full_array
         assign above_top = 1'b0;
      end
   endgenerate

   always_comb begin
      route_o        = '0;
      route_o.to_ext = (mode_i == MODE_EXT);
      route_o.to_nop = (mode_i == MODE_INT) && above_top;
      route_o.to_int = (mode_i == MODE_INT) && !above_top;
   end

endmodule

// File: rtl/pfs_ctrl.sv
module pfs_ctrl
   import pfs_pkg::*;
#(
   parameter int unsigned       DATA_W   = 8,
   parameter logic [DATA_W-1:0] NOP_CODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  pfs_route_t        route_i,
   input  logic [DATA_W-1:0] iarr_data_i,
   input  logic              xack_i,
   input  logic [DATA_W-1:0] xdata_i,
   output logic              ready_o,
   output logic              accept_o,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o,
   output logic              iarr_rd_o,
   output logic              xreq_o
);

   pfs_state_e state_q, state_d;

   assign ready_o   = (state_q == ST_IDLE);
   assign accept_o  = req_i && ready_o;
   assign iarr_rd_o = accept_o && route_i.to_int;
   assign xreq_o    = (state_q == ST_XWAIT);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (accept_o) begin
               if (route_i.to_ext) begin
                  state_d = ST_XWAIT;
               end else if (route_i.to_nop) begin
                  state_d = ST_NOP;
               end else begin
                  state_d = ST_IWAIT;
               end
            end
         end
         ST_IWAIT: state_d = ST_IDLE;
         ST_NOP:   state_d = ST_IDLE;
         ST_XWAIT: begin
            if (xack_i) begin
               state_d = ST_IDLE;
            end
         end
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   always_comb begin
      valid_o = 1'b0;
      data_o  = '0;
      unique case (state_q)
         ST_IWAIT: begin
            valid_o = 1'b1;
            data_o  = iarr_data_i;
         end
         ST_NOP: begin
            valid_o = 1'b1;
            data_o  = NOP_CODE;
         end
         ST_XWAIT: begin
            valid_o = xack_i;
            data_o  = xdata_i;
         end
         default: begin
            valid_o = 1'b0;
            data_o  = '0;
         end
      endcase
   end

   // R9: a result is never presented while a new fetch could be taken
   p_valid_not_ready_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !ready_o);

   // R6: an array read is answered in the very next cycle
   p_int_latency_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      iarr_rd_o |=> valid_o);

   // R7: the bus request drops in the cycle after the acknowledge
   p_ack_ends_req_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      xreq_o && xack_i |=> !xreq_o);

endmodule

// File: rtl/progmem_fetch_sel.sv
module progmem_fetch_sel
   import pfs_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 16,
   parameter int unsigned       DATA_W   = 8,
   parameter int unsigned       INT_TOP  = 32'h0000_F800,
   parameter logic [DATA_W-1:0] NOP_CODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_strap_i,
   input  logic              fetch_req_i,
   input  logic              fetch_seq_i,
   input  logic [ADDR_W-1:0] fetch_addr_i,
   output logic              fetch_ready_o,
   output logic              fetch_valid_o,
   output logic [DATA_W-1:0] fetch_data_o,
   output logic              iarr_rd_o,
   output logic [ADDR_W-1:0] iarr_addr_o,
   input  logic [DATA_W-1:0] iarr_data_i,
   output logic              xbus_req_o,
   output logic [ADDR_W-1:0] xbus_addr_o,
   input  logic              xbus_ack_i,
   input  logic [DATA_W-1:0] xbus_data_i
);

   localparam logic [ADDR_W:0] TOP_X = (ADDR_W+1)'(INT_TOP);

   generate
      if (ADDR_W < 2 || ADDR_W > 30) begin : g_bad_addr_w
         $error("progmem_fetch_sel: ADDR_W must lie in 2..30");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("progmem_fetch_sel: DATA_W must be at least 1");
      end
      if (INT_TOP == 0 || INT_TOP > (32'd1 << ADDR_W)) begin : g_bad_top
         $error("progmem_fetch_sel: INT_TOP must lie in 1..2^ADDR_W");
      end
   endgenerate

   pfs_mode_e         mode;
   pfs_route_t        route;
   logic              accept;
   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W-1:0] held_addr;

   pfs_mode_latch u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_i (boot_strap_i),
      .mode_o  (mode)
   );

   pfs_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .seq_i    (fetch_seq_i),
      .addr_i   (fetch_addr_i),
      .cur_o    (cur_addr),
      .held_o   (held_addr)
   );

   pfs_route #(.ADDR_W(ADDR_W), .INT_TOP(INT_TOP)) u_route (
      .mode_i  (mode),
      .addr_i  (cur_addr),
      .route_o (route)
   );

   pfs_ctrl #(.DATA_W(DATA_W), .NOP_CODE(NOP_CODE)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (fetch_req_i),
      .route_i     (route),
      .iarr_data_i (iarr_data_i),
      .xack_i      (xbus_ack_i),
      .xdata_i     (xbus_data_i),
      .ready_o     (fetch_ready_o),
      .accept_o    (accept),
      .valid_o     (fetch_valid_o),
      .data_o      (fetch_data_o),
      .iarr_rd_o   (iarr_rd_o),
      .xreq_o      (xbus_req_o)
   );

   assign iarr_addr_o = cur_addr;
   assign xbus_addr_o = held_addr;

   // R4: on-chip mode never drives the external bus
   p_no_xreq_int_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_INT) |-> !xbus_req_o);

   // R1: external mode never touches the on-chip array
   p_no_iarr_ext_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_EXT) |-> !iarr_rd_o);

   // R5: the array is never read at or above its end
   p_no_top_read_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      iarr_rd_o |-> ({1'b0, iarr_addr_o} < TOP_X));

   // R5: a completed on-chip fetch in the top region carries the NOP opcode
   p_nop_data_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid_o && (mode == MODE_INT) && ({1'b0, held_addr} >= TOP_X)
      |-> (fetch_data_o == NOP_CODE));

   // R7: the bus address stays put while a request waits
   p_xaddr_stable_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      xbus_req_o && $past(xbus_req_o) |-> $stable(xbus_addr_o));

endmodule

// File: tb/progmem_fetch_sel_test.sv
module progmem_fetch_sel_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap = 1'b1;
   logic        req = 1'b0;
   logic        seq = 1'b0;
   logic [15:0] addr = '0;
   logic        ready, valid, iarr_rd, xreq;
   logic [7:0]  data;
   logic [15:0] iarr_addr, xaddr;
   logic [7:0]  iarr_q = '0;
   logic        xack = 1'b0;
   logic [7:0]  xdata = '0;

   int total = 0;
   int bad = 0;
   int xlat = 0;
   int xcnt = 0;
   int xreq_cycles = 0;
   int iarr_reads = 0;
   int top_reads = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   progmem_fetch_sel uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .boot_strap_i  (strap),
      .fetch_req_i   (req),
      .fetch_seq_i   (seq),
      .fetch_addr_i  (addr),
      .fetch_ready_o (ready),
      .fetch_valid_o (valid),
      .fetch_data_o  (data),
      .iarr_rd_o     (iarr_rd),
      .iarr_addr_o   (iarr_addr),
      .iarr_data_i   (iarr_q),
      .xbus_req_o    (xreq),
      .xbus_addr_o   (xaddr),
      .xbus_ack_i    (xack),
      .xbus_data_i   (xdata)
   );

   function automatic logic [7:0] arr_byte(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   function automatic logic [7:0] bus_byte(input logic [15:0] a);
      return a[7:0] + a[15:8] + 8'h3C;
   endfunction

   // On-chip array model: one cycle read latency.
   always @(posedge clk) begin
      if (iarr_rd) begin
         iarr_q <= arr_byte(iarr_addr);
      end
   end

   // External bus model: acknowledge after xlat wait cycles.
   always @(posedge clk) begin
      if (xack) begin
         xack <= 1'b0;
         xcnt <= 0;
      end else if (xreq) begin
         if (xcnt == xlat) begin
            xack  <= 1'b1;
            xdata <= bus_byte(xaddr);
         end else begin
            xcnt <= xcnt + 1;
         end
      end
   end

   // Activity counters for ports that must stay quiet.
   always @(posedge clk) begin
      if (rst_n) begin
         if (xreq) xreq_cycles <= xreq_cycles + 1;
         if (iarr_rd) iarr_reads <= iarr_reads + 1;
         if (iarr_rd && iarr_addr >= 16'hF800) top_reads <= top_reads + 1;
      end
   end

   task automatic check(input string req_tag, input string what,
                        input int actual, input int expected);
      total++;
      if (actual != expected) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, actual, expected);
      end
   endtask

   task automatic do_reset(input logic s);
      @(negedge clk);
      rst_n = 1'b0;
      strap = s;
      req   = 1'b0;
      seq   = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Presents one fetch and waits for its result; lat counts falling edges after acceptance.
   task automatic do_fetch(input logic s, input logic [15:0] a, input bit poke,
                           output logic [7:0] d, output int lat);
      @(negedge clk);
      req  = 1'b1;
      seq  = s;
      addr = a;
      @(posedge clk);
      lat = 0;
      d   = '0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         lat++;
         if (poke) begin
            req  = 1'b1;
            seq  = 1'b0;
            addr = a ^ 16'h0F0F;
         end else begin
            req = 1'b0;
         end
         if (valid) begin
            d   = data;
            req = 1'b0;
            break;
         end
      end
      req = 1'b0;
   endtask

   task automatic t_reset_state;
      do_reset(1'b1);
      #1;
      check("R9", "ready after reset", int'(ready), 1);
      check("R9", "valid after reset", int'(valid), 0);
      check("R9", "bus request after reset", int'(xreq), 0);
      check("R9", "array strobe after reset", int'(iarr_rd), 0);
   endtask

   task automatic t_internal_reads;
      logic [7:0] d;
      int lat;
      int x0;
      logic [15:0] list [3] = '{16'h0000, 16'h1234, 16'hF7FF};
      x0 = xreq_cycles;
      foreach (list[k]) begin
         do_fetch(1'b0, list[k], 1'b0, d, lat);
         check("R2", "on-chip data", int'(d), int'(arr_byte(list[k])));
         check("R6", "on-chip latency", lat, 1);
      end
      check("R4", "bus quiet for on-chip reads", xreq_cycles - x0, 0);
   endtask

   task automatic t_top_region;
      logic [7:0] d;
      int lat;
      int x0, t0;
      logic [15:0] list [3] = '{16'hF800, 16'hFABC, 16'hFFFF};
      x0 = xreq_cycles;
      t0 = top_reads;
      foreach (list[k]) begin
         do_fetch(1'b0, list[k], 1'b0, d, lat);
         check("R5", "top region opcode", int'(d), 0);
         check("R5", "top region latency", lat, 1);
      end
      check("R4", "no bus request from top region", xreq_cycles - x0, 0);
      check("R5", "no array read in top region", top_reads - t0, 0);
   endtask

   task automatic t_wrap_internal;
      logic [7:0] d;
      int lat;
      int x0;
      x0 = xreq_cycles;
      do_fetch(1'b0, 16'hFFFE, 1'b0, d, lat);
      check("R5", "FFFE opcode", int'(d), 0);
      do_fetch(1'b1, 16'h0000, 1'b0, d, lat);
      check("R8", "sequential to FFFF", int'(d), 0);
      do_fetch(1'b1, 16'h5555, 1'b0, d, lat);
      check("R8", "wrap to 0000 on-chip", int'(d), int'(arr_byte(16'h0000)));
      do_fetch(1'b1, 16'h5555, 1'b0, d, lat);
      check("R8", "step to 0001 on-chip", int'(d), int'(arr_byte(16'h0001)));
      check("R8", "wrap stayed off the bus", xreq_cycles - x0, 0);
   endtask

   task automatic t_strap_ignored_int;
      logic [7:0] d;
      int lat;
      int x0;
      @(negedge clk);
      strap = 1'b0;
      x0 = xreq_cycles;
      do_fetch(1'b0, 16'h2000, 1'b0, d, lat);
      check("R3", "late strap low ignored", int'(d), int'(arr_byte(16'h2000)));
      check("R3", "late strap low no bus", xreq_cycles - x0, 0);
   endtask

   task automatic t_external_mode;
      logic [7:0] d;
      int lat;
      int i0;
      logic [15:0] list [3] = '{16'h0100, 16'hF800, 16'hFFFF};
      do_reset(1'b0);
      i0 = iarr_reads;
      xlat = 0;
      do_fetch(1'b1, 16'h0000, 1'b0, d, lat);
      check("R8", "first sequential fetch is 0000", int'(d), int'(bus_byte(16'h0000)));
      foreach (list[k]) begin
         do_fetch(1'b0, list[k], 1'b0, d, lat);
         check("R1", "external data", int'(d), int'(bus_byte(list[k])));
         check("R7", "external latency", lat, 2);
      end
      do_fetch(1'b1, 16'h0000, 1'b0, d, lat);
      check("R8", "external wrap to 0000", int'(d), int'(bus_byte(16'h0000)));
      check("R1", "array untouched in external mode", iarr_reads - i0, 0);
   endtask

   task automatic t_slow_bus_busy;
      logic [7:0] d;
      int lat;
      int extra;
      xlat = 3;
      do_fetch(1'b0, 16'h4321, 1'b1, d, lat);
      check("R7", "slow bus data", int'(d), int'(bus_byte(16'h4321)));
      check("R7", "slow bus latency", lat, 5);
      extra = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (valid) extra++;
      end
      check("R9", "request during wait ignored", extra, 0);
      xlat = 0;
   endtask

   task automatic t_strap_ignored_ext;
      logic [7:0] d;
      int lat;
      @(negedge clk);
      strap = 1'b1;
      do_fetch(1'b0, 16'h0100, 1'b0, d, lat);
      check("R3", "late strap high ignored", int'(d), int'(bus_byte(16'h0100)));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_internal_reads();
      t_top_region();
      t_wrap_internal();
      t_strap_ignored_int();
      t_external_mode();
      t_slow_bus_busy();
      t_strap_ignored_ext();
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule